// File: doc/BRIEF.md
# Fault capture ring buffer

The block records a stream of fixed-width sample frames into a circular store of `DEPTH` entries, overwriting the oldest entry once the store is full. A fault trigger ends free recording. The block then records a programmed number of further frames and freezes. The frozen capture holds the frames leading up to the fault and the frames that followed it, so an incident can be inspected with its history.

A reader then drains the capture one frame per request, oldest first. From the trigger until the last frame has been taken, an interlock output is held high. While the interlock is high the block cannot be re-armed and further triggers are ignored. Frames that arrive while the store cannot accept them raise a sticky overflow flag, which only an explicit clear input lowers. An arm pulse given after the readout is complete returns the block to free recording with an empty history.

Top module: `fault_capture_ring`

## Requirements
- R1: While recording, each frame presented with `in_valid` high is stored. Once `DEPTH` frames are held, each new frame replaces the oldest one.
- R2: A `fault_trig` seen while recording sets P = min(`post_count`, `DEPTH`). The capture then keeps min(frames held, `DEPTH` - P) frames from before the trigger plus the next P accepted frames. A frame accepted in the trigger cycle counts as a pre-trigger frame. From the cycle after the trigger, `capture_len` shows the kept pre-trigger count plus P.
- R3: Once the P post-trigger frames are stored, `rd_valid` rises. `rd_data` then shows the oldest kept frame and holds it until `rd_req` is sampled high. Each sampled `rd_req` moves to the next frame in arrival order. `rd_last` is high while the final frame is shown.
- R4: `interlock` is high from the cycle after an accepted trigger until the cycle after the final frame is taken. `rd_valid` is never high without `interlock`.
- R5: `fault_trig` has no effect during post-trigger recording, while frozen, or after readout before re-arming.
- R6: `arm` takes effect only after the readout has completed. It restarts recording with an empty history. At any other time it has no effect.
- R7: A frame arriving while the capture is frozen or already read out sets `ovf_flag`. The flag stays set until `ovf_clr` is sampled high. If a new overflow and `ovf_clr` occur in the same cycle, the flag stays set.
- R8: A trigger that comes before the store holds `DEPTH` - P frames is still accepted. `capture_len` is then shorter than `DEPTH`, and the readout covers only the frames actually stored.
- R9: With P = 0 the block freezes at the trigger itself. If no frame is held, the capture is empty: `interlock` and `rd_valid` stay low, `capture_len` is 0, and the block waits for `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame is present on `in_frame` |
| in_frame | input | FRAME_W | Sample frame |
| fault_trig | input | 1 | Fault trigger |
| post_count | input | $clog2(DEPTH)+1 | Post-trigger frame count, sampled at the trigger |
| arm | input | 1 | Return to recording after readout |
| rd_req | input | 1 | Reader takes the shown frame |
| rd_data | output | FRAME_W | Frame shown to the reader |
| rd_valid | output | 1 | `rd_data` holds a captured frame |
| rd_last | output | 1 | Shown frame is the final one |
| capture_len | output | $clog2(DEPTH)+1 | Number of frames in the capture |
| interlock | output | 1 | Capture in progress or not yet drained |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_clr | input | 1 | Clears `ovf_flag` |

## Verification
The main function is exercised with several kinds of history before the trigger. Long runs that wrap the store several times separate correct overwrite and oldest-first ordering from plain append order. Short histories that end before the pre-trigger window fills show whether the capture length follows the frames actually held rather than the programmed window. Post counts of zero, in range and above `DEPTH` check the immediate freeze, the normal split and the clamp. A frame in the trigger cycle, stray triggers and arm pulses during capture and readout, and frames pushed while frozen check that the capture content stays fixed and that only the overflow flag reacts.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      CAP_RECORD = 2'd0,
      CAP_POST   = 2'd1,
      CAP_FROZEN = 2'd2,
      CAP_DONE   = 2'd3
   } cap_state_e;
endpackage

// File: rtl/cap_ring_store.sv
module cap_ring_store #(
   parameter int W     = 12,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cap_sticky_flag.sv
module cap_sticky_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (clr) flag_q <= 1'b0;
            else if (set) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag = flag_q;
endmodule

// File: rtl/cap_seq.sv
module cap_seq
   import cap_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          fault_trig,
   input  logic          arm,
   input  logic          rd_req,
   input  logic [CW-1:0] post_count,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic          rd_valid,
   output logic          rd_last,
   output logic          interlock,
   output logic          block_in,
   output logic [CW-1:0] capture_len
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   cap_state_e    state_q;
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] fill_q, post_q, rem_q, len_q;

   logic          accept;
   logic [AW-1:0] wp_inc, wp_next;
   logic [CW-1:0] fill_now, post_eff, room, pre_keep;

   always_comb begin
      accept   = in_valid && (state_q == CAP_RECORD || state_q == CAP_POST);
      wp_inc   = wp_q + AW'(1);
      wp_next  = accept ? wp_inc : wp_q;
      fill_now = (accept && fill_q != FULL) ? fill_q + ONE : fill_q;
      post_eff = (post_count > FULL) ? FULL : post_count;
      room     = FULL - post_eff;
      pre_keep = (fill_now > room) ? room : fill_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CAP_RECORD;
         wp_q    <= '0;
         rp_q    <= '0;
         fill_q  <= '0;
         post_q  <= '0;
         rem_q   <= '0;
         len_q   <= '0;
      end else begin
         if (accept) wp_q <= wp_inc;
         case (state_q)
            CAP_RECORD: begin
               fill_q <= fill_now;
               if (fault_trig) begin
                  len_q <= pre_keep + post_eff;
                  if (post_eff == '0) begin
                     rp_q    <= wp_next - pre_keep[AW-1:0];
                     rem_q   <= pre_keep;
                     state_q <= (pre_keep == '0) ? CAP_DONE : CAP_FROZEN;
                  end else begin
                     post_q  <= post_eff;
                     state_q <= CAP_POST;
                  end
               end
            end
            CAP_POST: begin
               if (in_valid) begin
                  post_q <= post_q - ONE;
                  if (post_q == ONE) begin
                     rp_q    <= wp_inc - len_q[AW-1:0];
                     rem_q   <= len_q;
                     state_q <= CAP_FROZEN;
                  end
               end
            end
            CAP_FROZEN: begin
               if (rd_req) begin
                  rp_q  <= rp_q + AW'(1);
                  rem_q <= rem_q - ONE;
                  if (rem_q == ONE) state_q <= CAP_DONE;
               end
            end
            default: begin
               if (arm) begin
                  state_q <= CAP_RECORD;
                  fill_q  <= '0;
               end
            end
         endcase
      end
   end

   assign we          = accept;
   assign waddr       = wp_q;
   assign raddr       = rp_q;
   assign rd_valid    = (state_q == CAP_FROZEN);
   assign rd_last     = (state_q == CAP_FROZEN) && (rem_q == ONE);
   assign interlock   = (state_q == CAP_POST) || (state_q == CAP_FROZEN);
   assign block_in    = (state_q == CAP_FROZEN) || (state_q == CAP_DONE);
   assign capture_len = len_q;
endmodule

// File: rtl/fault_capture_ring.sv
module fault_capture_ring #(
   parameter int FRAME_W      = 12,
   parameter int DEPTH        = 8,
   parameter bit OVF_SET_WINS = 1'b1,
   localparam int AW          = $clog2(DEPTH),
   localparam int CW          = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FRAME_W-1:0] in_frame,
   input  logic               fault_trig,
   input  logic [CW-1:0]      post_count,
   input  logic               arm,
   input  logic               rd_req,
   output logic [FRAME_W-1:0] rd_data,
   output logic               rd_valid,
   output logic               rd_last,
   output logic [CW-1:0]      capture_len,
   output logic               interlock,
   output logic               ovf_flag,
   input  logic               ovf_clr
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (FRAME_W < 1) begin : g_bad_width
         $error("FRAME_W must be at least 1");
      end
   endgenerate

   logic          we, block_in;
   logic [AW-1:0] waddr, raddr;

   cap_seq #(.DEPTH(DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .fault_trig (fault_trig),
      .arm        (arm),
      .rd_req     (rd_req),
      .post_count (post_count),
      .we         (we),
      .waddr      (waddr),
      .raddr      (raddr),
      .rd_valid   (rd_valid),
      .rd_last    (rd_last),
      .interlock  (interlock),
      .block_in   (block_in),
      .capture_len(capture_len)
   );

   cap_ring_store #(.W(FRAME_W), .DEPTH(DEPTH)) u_store (
      .clk  (clk),
      .we   (we),
      .waddr(waddr),
      .wdata(in_frame),
      .raddr(raddr),
      .rdata(rd_data)
   );

   cap_sticky_flag #(.SET_WINS(OVF_SET_WINS)) u_ovf (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (in_valid && block_in),
      .clr  (ovf_clr),
      .flag (ovf_flag)
   );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
   parameter int FRAME_W = 12,
   parameter int DEPTH   = 8,
   localparam int CW     = $clog2(DEPTH) + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               rd_req,
   input logic               rd_valid,
   input logic               rd_last,
   input logic               interlock,
   input logic               ovf_flag,
   input logic               ovf_clr,
   input logic [CW-1:0]      capture_len,
   input logic [FRAME_W-1:0] rd_data
);
   assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      capture_len <= CW'(DEPTH));

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_req |=> rd_valid && $stable(rd_data));

   assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

   assert_valid_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> interlock);

   assert_lock_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(interlock) |-> $past(rd_last && rd_req));

   assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(in_valid));

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag);
endmodule

bind fault_capture_ring cap_checker #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .rd_req     (rd_req),
   .rd_valid   (rd_valid),
   .rd_last    (rd_last),
   .interlock  (interlock),
   .ovf_flag   (ovf_flag),
   .ovf_clr    (ovf_clr),
   .capture_len(capture_len),
   .rd_data    (rd_data)
);

// File: tb/sim_fault_capture_ring.sv
`timescale 1ns/1ps
module sim_fault_capture_ring;
   localparam int W     = 12;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, fault_trig = 1'b0, arm = 1'b0;
   logic          rd_req = 1'b0, ovf_clr = 1'b0;
   logic [W-1:0]  in_frame = '0;
   logic [CW-1:0] post_count = '0;
   logic [W-1:0]  rd_data;
   logic          rd_valid, rd_last, interlock, ovf_flag;
   logic [CW-1:0] capture_len;

   int n_chk = 0, n_bad = 0;
   logic [W-1:0] hist[$];
   logic [W-1:0] expq[$];

   always #5 clk = ~clk;

   fault_capture_ring #(.FRAME_W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
      .fault_trig(fault_trig), .post_count(post_count), .arm(arm),
      .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_last(rd_last), .capture_len(capture_len), .interlock(interlock),
      .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic record(input logic [W-1:0] f);
      hist.push_back(f);
      if (hist.size() > DEPTH) void'(hist.pop_front());
   endtask

   task automatic push(input logic [W-1:0] f);
      in_valid = 1'b1; in_frame = f;
      tick();
      in_valid = 1'b0;
   endtask

   task automatic rearm();
      ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
      chk("R7 cleared", 32'(ovf_flag), 0);
      arm = 1'b1; tick(); arm = 1'b0;
      hist.delete();
      chk("R6 armed lock", 32'(interlock), 0);
   endtask

   // one capture: npre frames of history, trigger, post frames, readout
   task automatic run_case(input int npre, input int pc, input bit frame_on_trig, input bit noise);
      int peff, pre, lenx;
      logic [W-1:0] f;
      expq.delete();
      for (int i = 0; i < npre; i++) begin
         f = W'($urandom);
         push(f); record(f);
         if (noise && ($urandom_range(0, 2) == 0)) tick();
      end
      post_count = CW'(pc);
      fault_trig = 1'b1;
      if (frame_on_trig) begin
         f = W'($urandom); in_valid = 1'b1; in_frame = f; record(f);
      end
      tick();
      fault_trig = 1'b0; in_valid = 1'b0;
      peff = imin(pc, DEPTH);
      pre  = imin(hist.size(), DEPTH - peff);
      lenx = pre + peff;
      for (int k = hist.size() - pre; k < hist.size(); k++) expq.push_back(hist[k]);
      chk("R2 R8 capture_len", 32'(capture_len), 32'(lenx));
      if (lenx == 0) begin
         chk("R9 empty lock", 32'(interlock), 0);
         chk("R9 empty valid", 32'(rd_valid), 0);
      end else begin
         chk("R4 lock after trigger", 32'(interlock), 1);
      end
      for (int i = 0; i < peff; i++) begin
         if (noise && i == 0) begin
            fault_trig = 1'b1; arm = 1'b1; tick(); fault_trig = 1'b0; arm = 1'b0;
         end
         f = W'($urandom); push(f); expq.push_back(f);
      end
      if (lenx > 0) begin
         chk("R3 valid after post", 32'(rd_valid), 1);
         if (noise) begin
            fault_trig = 1'b1; in_valid = 1'b1; in_frame = W'($urandom);
            tick();
            fault_trig = 1'b0; in_valid = 1'b0;
            chk("R7 ovf while frozen", 32'(ovf_flag), 1);
            chk("R5 capture_len unchanged", 32'(capture_len), 32'(lenx));
         end
         for (int i = 0; i < lenx; i++) begin
            chk("R3 rd_data", 32'(rd_data), 32'(expq[i]));
            chk("R3 rd_last", 32'(rd_last), 32'(i == lenx - 1));
            if (noise && i == 1) begin
               arm = 1'b1; tick(); arm = 1'b0;
               chk("R6 arm ignored in readout", 32'(rd_data), 32'(expq[i]));
            end
            rd_req = 1'b1; tick(); rd_req = 1'b0;
         end
         chk("R4 lock released", 32'(interlock), 0);
         chk("R3 valid dropped", 32'(rd_valid), 0);
      end
      rearm();
   endtask

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
         end
      join_none
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R4 reset lock", 32'(interlock), 0);
      chk("R3 reset valid", 32'(rd_valid), 0);
      chk("R7 reset ovf", 32'(ovf_flag), 0);
      chk("R2 reset len", 32'(capture_len), 0);

      // R1: wrap the store, normal split
      run_case(20, 3, 1'b0, 1'b0);
      // R8: early trigger
      run_case(2, 2, 1'b0, 1'b1);
      // R9: immediate freeze with full history
      run_case(11, 0, 1'b1, 1'b0);
      // R9: empty capture
      run_case(0, 0, 1'b0, 1'b0);
      // R2: post count above depth clamps
      run_case(5, 12, 1'b0, 1'b1);

      // R7 set wins over clear; R6 frames after readout not kept
      post_count = CW'(0);
      push(12'h111); fault_trig = 1'b1; tick(); fault_trig = 1'b0;
      rd_req = 1'b1; tick(); rd_req = 1'b0;
      in_valid = 1'b1; ovf_clr = 1'b1; in_frame = 12'h222; tick();
      in_valid = 1'b0; ovf_clr = 1'b0;
      chk("R7 set beats clear", 32'(ovf_flag), 1);
      rearm();
      push(12'h333); hist.push_back(12'h333);
      fault_trig = 1'b1; tick(); fault_trig = 1'b0;
      chk("R6 history emptied by arm", 32'(capture_len), 1);
      chk("R6 only new frame", 32'(rd_data), 32'h333);
      rd_req = 1'b1; tick(); rd_req = 1'b0;
      rearm();

      for (int s = 0; s < 40; s++)
         run_case($urandom_range(0, 20), $urandom_range(0, 15),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule